// File: doc/BRIEF.md
# System Control Port with NMI Latching and Speaker Gate

This block is the byte-wide system control port of a PC-compatible chipset. Each bit of the byte has a fixed meaning. The four low bits are writable control: they drive the gate input of timer channel 2, pass that channel's output to the speaker, and enable or mask two error sources. The four high bits are read-only status:

- two sticky error flags;
- the live level of timer channel 2's output;
- a toggle that flips each time timer channel 1's output falls.

Both error sources are active low. One is a combined parity/system error line; the other is an I/O channel check line. A latched error raises a non-maskable interrupt request, which stays high until software writes 1 to the matching enable bit. That write masks the source and clears its flag.

The error inputs and both timer outputs are asynchronous. Each one passes through a synchronizer before the block samples or edge-detects it. The speaker path is the one exception: it gates the raw channel 2 output, so the audio waveform sees no added delay.

Top module: `sysctl_port`

## Requirements
- R1: While reset is held and right after it is released, rdData is 8'b0000_1100, provided tmr2Out is 0. This means both error enables are 1 (masked) and the gate and speaker bits are 0. The outputs gate2, spkr and nmiReq are all 0.
- R2: A write stores wrData[3:0] into bits [3:0], and rdData[3:0] shows the stored value on the next cycle. Write data in bits [7:4] is ignored, and the status bits are left unchanged by it.
- R3: Output gate2 always equals control bit 0.
- R4: Output spkr equals tmr2Out AND control bit 1, with no clock delay. When bit 1 is 0, spkr is 0.
- R5: rdData[5] follows tmr2Out within SYNC_STAGES+1 clock cycles.
- R6: rdData[4] inverts once for each falling edge of tmr1Out. A rising edge leaves it unchanged.
- R7: While control bit 2 is 0, a low level on busErrN sets rdData[7]. The flag stays set after busErrN returns high.
- R8: While control bit 2 is 1, busErrN is ignored: rdData[7] and nmiReq stay 0.
- R9: Any write with wrData[2]=1 clears rdData[7] on the next cycle. This holds even while busErrN is still low.
- R10: rdData[6] behaves in the same way, using chanChkN and control bit 3. It latches while bit 3 is 0, ignores the input while bit 3 is 1, and clears on any write with wrData[3]=1.
- R11: nmiReq equals rdData[7] OR rdData[6].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the port byte |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte (status and control) |
| busErrN | input | 1 | Parity/system error, active low, asynchronous |
| chanChkN | input | 1 | I/O channel check, active low, asynchronous |
| tmr1Out | input | 1 | Timer channel 1 output |
| tmr2Out | input | 1 | Timer channel 2 output |
| gate2 | output | 1 | Gate input for timer channel 2 |
| spkr | output | 1 | Speaker drive |
| nmiReq | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with the default SYNC_STAGES of 2, which keeps input-to-status latency short. Every waiting window is a few cycles wide at most.

This small configuration makes the sweeps near-exhaustive:

- Writes: all 256 byte values, each checked against the stored low nibble, gate2, and spkr for both levels of tmr2Out.
- Errors: all sixteen combinations of the two enable bits and the two error inputs, each with its expected status and NMI level.
- Toggle: a run of channel 1 pulses, where the toggle bit is predicted from the count of falling edges.
- Clear under error: clearing a flag while its error input is still held low.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Read-back bit positions of the port byte (software-visible layout)
  localparam int BIT_GATE   = 0;
  localparam int BIT_SPKEN  = 1;
  localparam int BIT_BUSDIS = 2;
  localparam int BIT_CHKDIS = 3;
  localparam int BIT_TGL    = 4;
  localparam int BIT_T2     = 5;
  localparam int BIT_CHKST  = 6;
  localparam int BIT_BUSST  = 7;

  localparam logic [3:0] CTRL_RESET = 4'b1100;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic setBus;
    logic setChk;
    logic clrBus;
    logic clrChk;
    logic flipTgl;
  } strobe_t;

endpackage

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[b] <= '0;
      else       chain[b] <= {chain[b][STAGES-2:0], dIn[b]};
    end
    assign dOut[b] = chain[b][STAGES-1];
  end

endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    wrBusDis,
  input  logic    wrChkDis,
  input  logic    busErrS,
  input  logic    chkErrS,
  input  logic    tmr1S,
  input  logic    busDis,
  input  logic    chkDis,
  output strobe_t stb
);

  logic tmr1Prev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmr1Prev <= 1'b0;
    else       tmr1Prev <= tmr1S;
  end

  always_comb begin
    stb         = '0;
    stb.wrCtrl  = wrEn;
    stb.clrBus  = wrEn && wrBusDis;
    stb.clrChk  = wrEn && wrChkDis;
    stb.setBus  = busErrS && !busDis;
    stb.setChk  = chkErrS && !chkDis;
    stb.flipTgl = tmr1Prev && !tmr1S;
  end

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [3:0] wrNib,
  input  logic       tmr2S,
  output logic [7:0] portByte,
  output logic       busDis,
  output logic       chkDis,
  output logic       gateOut,
  output logic       spkEn,
  output logic       nmiOut
);

  logic [3:0] ctrlReg;
  logic       busSt;
  logic       chkSt;
  logic       tglBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      busSt   <= 1'b0;
      chkSt   <= 1'b0;
      tglBit  <= 1'b0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= wrNib;
      // clear has priority over set in the same cycle
      if (stb.clrBus)      busSt <= 1'b0;
      else if (stb.setBus) busSt <= 1'b1;
      if (stb.clrChk)      chkSt <= 1'b0;
      else if (stb.setChk) chkSt <= 1'b1;
      if (stb.flipTgl) tglBit <= ~tglBit;
    end
  end

  always_comb begin
    portByte            = '0;
    portByte[3:0]       = ctrlReg;
    portByte[BIT_TGL]   = tglBit;
    portByte[BIT_T2]    = tmr2S;
    portByte[BIT_CHKST] = chkSt;
    portByte[BIT_BUSST] = busSt;
  end

  assign busDis  = ctrlReg[BIT_BUSDIS];
  assign chkDis  = ctrlReg[BIT_CHKDIS];
  assign gateOut = ctrlReg[BIT_GATE];
  assign spkEn   = ctrlReg[BIT_SPKEN];
  assign nmiOut  = busSt | chkSt;

endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       busErrN,
  input  logic       chanChkN,
  input  logic       tmr1Out,
  input  logic       tmr2Out,
  output logic       gate2,
  output logic       spkr,
  output logic       nmiReq
);

  localparam int NUM_ASYNC = 4;

  logic [NUM_ASYNC-1:0] rawIn;
  logic [NUM_ASYNC-1:0] syncIn;
  strobe_t              stb;
  logic                 busDis;
  logic                 chkDis;
  logic                 spkEn;
  logic                 unusedHiBits;

  // active-low error lines inverted before sync so every flop resets to 0
  assign rawIn        = {tmr2Out, tmr1Out, ~chanChkN, ~busErrN};
  assign unusedHiBits = ^wrData[7:4];

  sysctl_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawIn),
    .dOut (syncIn)
  );

  sysctl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrBusDis (wrData[BIT_BUSDIS]),
    .wrChkDis (wrData[BIT_CHKDIS]),
    .busErrS  (syncIn[0]),
    .chkErrS  (syncIn[1]),
    .tmr1S    (syncIn[2]),
    .busDis   (busDis),
    .chkDis   (chkDis),
    .stb      (stb)
  );

  sysctl_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrNib    (wrData[3:0]),
    .tmr2S    (syncIn[3]),
    .portByte (rdData),
    .busDis   (busDis),
    .chkDis   (chkDis),
    .gateOut  (gate2),
    .spkEn    (spkEn),
    .nmiOut   (nmiReq)
  );

  assign spkr = tmr2Out & spkEn;

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       busErrN,
  input logic       chanChkN,
  input logic       tmr1Out,
  input logic       tmr2Out,
  input logic       gate2,
  input logic       spkr,
  input logic       nmiReq
);

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[3:0] == $past(wrData[3:0])); // R2

  AST_SPKR_MUTED: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[1] |-> !spkr); // R4

  AST_BUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && !(wrEn && wrData[2])) |=> rdData[7]); // R7

  AST_BUS_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2] && !rdData[7] && !wrEn) |=> !rdData[7]); // R8

  AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[2]) |=> !rdData[7]); // R9

  AST_CHK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[3]) |=> !rdData[6]); // R10

  AST_NMI_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq == (rdData[7] || rdData[6])); // R11

endmodule

bind sysctl_port sysctl_chk u_chk (.*);

// File: tb/sim_sysctl_port.sv
module sim_sysctl_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       busErrN = 1'b1;
  logic       chanChkN = 1'b1;
  logic       tmr1Out = 1'b0;
  logic       tmr2Out = 1'b0;
  logic [7:0] rdData;
  logic       gate2, spkr, nmiReq;

  int runCnt = 0;
  int failCnt = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  sysctl_port #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .busErrN(busErrN), .chanChkN(chanChkN), .tmr1Out(tmr1Out), .tmr2Out(tmr2Out),
    .gate2(gate2), .spkr(spkr), .nmiReq(nmiReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic portWrite(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!doneFlag) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int tglExp;
    int falls;
    idle(3);
    check("R1 rd in reset", rdData, 8'h0C);
    check("R1 outs in reset", {gate2, spkr, nmiReq}, 3'b000);
    @(negedge clk) rstN = 1'b1;
    idle(2);
    check("R1 rd after reset", rdData, 8'h0C);
    check("R1 outs after reset", {gate2, spkr, nmiReq}, 3'b000);

    // R2 R3 R4: every write value, both speaker input levels
    for (int v = 0; v < 256; v++) begin
      portWrite(v[7:0]);
      check("R2 stored nibble", rdData[3:0], v[3:0]);
      check("R2 status untouched", rdData[7:4], 4'h0);
      check("R3 gate2", gate2, v[0]);
      tmr2Out = 1'b1; #1;
      check("R4 spkr high input", spkr, v[1]);
      tmr2Out = 1'b0; #1;
      check("R4 spkr low input", spkr, 1'b0);
    end

    // R5: bit 5 follows channel 2 after sync
    portWrite(8'h0C);
    tmr2Out = 1'b1; idle(3);
    check("R5 t2 high", rdData[5], 1'b1);
    tmr2Out = 1'b0; idle(3);
    check("R5 t2 low", rdData[5], 1'b0);

    // R6: toggle counts falling edges only
    tglExp = 0;
    for (int p = 0; p < 7; p++) begin
      tmr1Out = 1'b1; idle(4);
      check("R6 rise no flip", rdData[4], tglExp[0]);
      tmr1Out = 1'b0; idle(4);
      tglExp ^= 1;
      check("R6 fall flips", rdData[4], tglExp[0]);
    end
    falls = 7;
    check("R6 parity", rdData[4], falls % 2);

    // R7 R8 R10 R11: all enable and input combinations
    for (int c = 0; c < 16; c++) begin
      logic e2, e3, a, b;
      e2 = c[0]; e3 = c[1]; a = c[2]; b = c[3];
      portWrite({4'h0, e3, e2, 2'b00});
      busErrN = ~a; chanChkN = ~b;
      idle(4);
      busErrN = 1'b1; chanChkN = 1'b1;
      idle(4);
      check("R7 R8 bus status", rdData[7], a & ~e2);
      check("R10 chk status", rdData[6], b & ~e3);
      check("R11 nmi", nmiReq, (a & ~e2) | (b & ~e3));
      portWrite(8'h0C);
      check("R9 bus cleared", rdData[7], 1'b0);
      check("R10 chk cleared", rdData[6], 1'b0);
      check("R11 nmi cleared", nmiReq, 1'b0);
    end

    // R9 R10: clear while the error line is still low
    portWrite(8'h00);
    busErrN = 1'b0; chanChkN = 1'b0;
    idle(4);
    check("R7 latched", rdData[7], 1'b1);
    check("R10 latched", rdData[6], 1'b1);
    portWrite(8'h04);
    check("R9 clear under error", rdData[7], 1'b0);
    check("R10 chk remains", rdData[6], 1'b1);
    idle(3);
    check("R9 stays clear", rdData[7], 1'b0);
    portWrite(8'h0C);
    check("R10 clear under error", rdData[6], 1'b0);
    check("R11 nmi off", nmiReq, 1'b0);
    busErrN = 1'b1; chanChkN = 1'b1;
    idle(3);

    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule